// File: doc/BRIEF.md
# Dual-Counter Timestamp Reconciler

This block produces a 24-bit event timestamp from two 16-bit free-running counters that each capture the same asynchronous event. The fine counter advances on every clock. The coarse counter advances once per 256 clocks. As a result, the coarse counter's low byte always repeats the fine counter's high byte. Each counter has its own two-flop synchronizer and its own capture register. An extra per-path delay of zero to `MAX_LAG` cycles is selected at the ports, so the two captures of one edge can land in different cycles.

Once both captures of an event are held, the block compares the byte the two counters share. If the skew carried the coarse counter's low byte across a wrap that the fine counter did not see, or the other way round, the coarse counter's top byte is repaired. The result is that top byte placed above all 16 fine bits, flagged valid one cycle after the later capture. The result and its flag hold for any length of time until either path captures a new edge. The two counters are brought out so that their alignment can be observed.

Top module: `dual_stamp_capture`

## Requirements
- R1: Out of reset the fine count increases by one on every clock and the coarse count by one every 256 clocks, so coarse bits [7:0] always equal fine bits [15:8], and {coarse, fine[7:0]} equals the number of clocks since reset, modulo 2^24.
- R2: While reset is low, both counts, the timestamp and the valid flag are zero.
- R3: A path with lag L captures, on a rising edge of the event, the count present 2+L clocks after the edge is applied. Bits [15:0] of the timestamp equal the fine capture.
- R4: The valid flag rises on the clock after the later of the two captures of one event. Before that, it is low.
- R5: If the shared byte is 0xFF in the fine capture and 0x00 in the coarse capture, timestamp bits [23:16] are the coarse top byte minus one.
- R6: If the shared byte is 0x00 in the fine capture and 0xFF in the coarse capture, timestamp bits [23:16] are the coarse top byte plus one.
- R7: In every other case, including equal shared bytes and mismatches away from the byte wrap, timestamp bits [23:16] are the coarse top byte unchanged.
- R8: Once valid, the flag and the timestamp stay unchanged for as long as no path captures a new edge.
- R9: A new capture on either path clears the valid flag on the next clock.
- R10: A lag input value above `MAX_LAG` (2 by default) acts as `MAX_LAG`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 1 | Asynchronous event; its rising edge is captured |
| fast_lag_i | input | 2 | Extra capture delay of the fine path, in cycles |
| slow_lag_i | input | 2 | Extra capture delay of the coarse path, in cycles |
| fast_cnt_o | output | 16 | Live fine count |
| slow_cnt_o | output | 16 | Live coarse count |
| stamp_o | output | 24 | Reconciled timestamp |
| stamp_vld_o | output | 1 | Timestamp valid |

## Verification
A wrong prescaler or counter shows up at once as a coarse low byte that differs from the fine high byte. It also shows as a live count that departs from the ideal clock count. A wrong lag tap or edge detector moves the low 16 timestamp bits away from the ideal count by whole cycles, and this is visible on the first event. A faulty repair only appears when a skewed pair straddles a coarse low-byte wrap. For that reason the bench steers events onto 256-clock boundaries and onto the two 65536-clock boundaries within reach. A wrong top byte there differs from the ideal 24-bit count by 65536.

// File: rtl/stamp_pkg.sv
// Shared definitions for the dual-counter timestamp reconciler.
// Assumes the coarse counter's prescale is a power of two that is narrower
// than the fine counter.
package stamp_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Action taken on the coarse top byte after comparing the shared byte
    typedef enum logic [1:0] {
        FIX_NONE = 2'd0,
        FIX_DEC  = 2'd1,
        FIX_INC  = 2'd2
    } fix_e;

    // Width of the merged stamp: coarse bits above the shared byte plus all fine bits
    function automatic int stamp_width(input int fast_w, input int pre_log2, input int slow_w);
        return slow_w - (fast_w - pre_log2) + fast_w;
    endfunction
endpackage

// File: rtl/tick_counters.sv
// Fine and coarse free-running counters.
// The fine counter steps every clock. The coarse counter steps when an
// independent prescaler wraps. Both leave the same synchronous reset, so the
// coarse low bits track the fine high bits from the start.
module tick_counters #(
    parameter int FAST_W   = 16,
    parameter int PRE_LOG2 = 8,
    parameter int SLOW_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [FAST_W-1:0] fast_o,
    output logic [SLOW_W-1:0] slow_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int OV_W = FAST_W - PRE_LOG2;

    logic [PRE_LOG2-1:0] pre_q;
    logic                tick;

    assign tick = &pre_q;

    // Advance prescaler and both counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            fast_o <= '0;
            slow_o <= '0;
        end else begin
            pre_q  <= pre_q + 1'b1;
            fast_o <= fast_o + 1'b1;
            if (tick) begin
                slow_o <= slow_o + 1'b1;
            end
        end
    end

    // R1
    ov_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_o[OV_W-1:0] == fast_o[FAST_W-1:PRE_LOG2]);

    // R1
    fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> fast_o == FAST_W'($past(fast_o) + 1'b1));
endmodule

// File: rtl/capture_path.sv
// One capture channel: a two-flop synchronizer, a delay line with a selectable
// tap, a rising-edge detector and a capture register.
// Assumes MAX_LAG >= 1 and that the lag input is held steady while the event
// is propagating.
module capture_path #(
    parameter int CNT_W   = 16,
    parameter int MAX_LAG = 2,
    parameter int LAG_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic [LAG_W-1:0] lag_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             stb_o,
    output logic [CNT_W-1:0] cap_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [LAG_W-1:0] LAG_TOP = LAG_W'(MAX_LAG);

    logic             s1_q;
    logic [MAX_LAG:0] tap_q;
    logic             prev_q;
    logic [LAG_W-1:0] sel;
    logic             sig;

    // Synchronize the event and shift it down the delay line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q  <= 1'b0;
            tap_q <= '0;
        end else begin
            s1_q  <= evt_i;
            tap_q <= {tap_q[MAX_LAG-1:0], s1_q};
        end
    end

    // Clamp the lag and pick the tap
    always_comb begin
        sel = (lag_i > LAG_TOP) ? LAG_TOP : lag_i;
        sig = tap_q[sel];
    end

    assign stb_o = sig & ~prev_q;

    // Remember the tap level and load the count on a rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cap_o  <= '0;
        end else begin
            prev_q <= sig;
            if (stb_o) begin
                cap_o <= cnt_i;
            end
        end
    end

    // R3
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> cap_o == $past(cnt_i));
endmodule

// File: rtl/stamp_merge.sv
// Pairs one fine and one coarse capture and forms the merged stamp.
// The shared byte is compared. When one side has wrapped past 0xFF and the
// other has not, the coarse top byte is stepped by one.
// Assumes the two captures of one event are less than 256 clocks apart.
module stamp_merge
    import stamp_pkg::*;
#(
    parameter int FAST_W   = 16,
    parameter int PRE_LOG2 = 8,
    parameter int SLOW_W   = 16,
    localparam int STAMP_W = stamp_width(FAST_W, PRE_LOG2, SLOW_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fast_stb_i,
    input  logic [FAST_W-1:0]  fast_cap_i,
    input  logic               slow_stb_i,
    input  logic [SLOW_W-1:0]  slow_cap_i,
    output logic [STAMP_W-1:0] stamp_o,
    output logic               vld_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int OV_W  = FAST_W - PRE_LOG2;
    localparam int TOP_W = SLOW_W - OV_W;

    logic [OV_W-1:0]  fast_hi;
    logic [OV_W-1:0]  slow_lo;
    logic [TOP_W-1:0] slow_top;
    logic [TOP_W-1:0] top_fix;
    fix_e             fix;
    logic             fast_have_q;
    logic             slow_have_q;
    logic             ready;
    logic             any_stb;

    assign fast_hi  = fast_cap_i[FAST_W-1:PRE_LOG2];
    assign slow_lo  = slow_cap_i[OV_W-1:0];
    assign slow_top = slow_cap_i[SLOW_W-1:OV_W];
    assign ready    = fast_have_q & slow_have_q;
    assign any_stb  = fast_stb_i | slow_stb_i;

    // Classify the shared-byte comparison
    always_comb begin
        if ((&fast_hi) && (slow_lo == '0)) begin
            fix = FIX_DEC;
        end else if ((fast_hi == '0) && (&slow_lo)) begin
            fix = FIX_INC;
        end else begin
            fix = FIX_NONE;
        end
    end

    // Apply the repair to the coarse top byte
    always_comb begin
        case (fix)
            FIX_DEC: top_fix = slow_top - 1'b1;
            FIX_INC: top_fix = slow_top + 1'b1;
            default: top_fix = slow_top;
        endcase
    end

    // Track which captures are pending and publish the merged stamp
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_have_q <= 1'b0;
            slow_have_q <= 1'b0;
            vld_o       <= 1'b0;
            stamp_o     <= '0;
        end else begin
            fast_have_q <= (fast_have_q & ~ready) | fast_stb_i;
            slow_have_q <= (slow_have_q & ~ready) | slow_stb_i;
            if (any_stb) begin
                vld_o <= 1'b0;
            end else if (ready) begin
                vld_o   <= 1'b1;
                stamp_o <= {top_fix, fast_cap_i};
            end
        end
    end

    // R3
    low_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !any_stb |=> stamp_o[FAST_W-1:0] == $past(fast_cap_i));

    // R5 R6 R7: the upper stamp bits stay within one coarse step of the coarse capture
    near_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !any_stb |=>
            SLOW_W'(stamp_o[STAMP_W-1:PRE_LOG2] - $past(slow_cap_i) + 1'b1) <= SLOW_W'(2));

    // R4
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !any_stb |=> vld_o);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o && !any_stb |=> vld_o && $stable(stamp_o));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !vld_o);
endmodule

// File: rtl/dual_stamp_capture.sv
// Top of the dual-counter timestamp reconciler.
// It holds the two counters, one capture path per counter and the merge stage.
// Assumes both paths see the same event pin and that events are spaced
// further apart than the synchronizer plus the longest lag.
module dual_stamp_capture
    import stamp_pkg::*;
#(
    parameter int FAST_W   = 16,
    parameter int PRE_LOG2 = 8,
    parameter int SLOW_W   = 16,
    parameter int MAX_LAG  = 2,
    localparam int LAG_W   = $clog2(MAX_LAG + 1),
    localparam int STAMP_W = stamp_width(FAST_W, PRE_LOG2, SLOW_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_i,
    input  logic [LAG_W-1:0]   fast_lag_i,
    input  logic [LAG_W-1:0]   slow_lag_i,
    output logic [FAST_W-1:0]  fast_cnt_o,
    output logic [SLOW_W-1:0]  slow_cnt_o,
    output logic [STAMP_W-1:0] stamp_o,
    output logic               stamp_vld_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic              fast_stb;
    logic              slow_stb;
    logic [FAST_W-1:0] fast_cap;
    logic [SLOW_W-1:0] slow_cap;

    tick_counters #(
        .FAST_W  (FAST_W),
        .PRE_LOG2(PRE_LOG2),
        .SLOW_W  (SLOW_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .fast_o(fast_cnt_o),
        .slow_o(slow_cnt_o)
    );

    capture_path #(
        .CNT_W  (FAST_W),
        .MAX_LAG(MAX_LAG),
        .LAG_W  (LAG_W)
    ) u_fast_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .evt_i(evt_i),
        .lag_i(fast_lag_i),
        .cnt_i(fast_cnt_o),
        .stb_o(fast_stb),
        .cap_o(fast_cap)
    );

    capture_path #(
        .CNT_W  (SLOW_W),
        .MAX_LAG(MAX_LAG),
        .LAG_W  (LAG_W)
    ) u_slow_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .evt_i(evt_i),
        .lag_i(slow_lag_i),
        .cnt_i(slow_cnt_o),
        .stb_o(slow_stb),
        .cap_o(slow_cap)
    );

    stamp_merge #(
        .FAST_W  (FAST_W),
        .PRE_LOG2(PRE_LOG2),
        .SLOW_W  (SLOW_W)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_stb_i(fast_stb),
        .fast_cap_i(fast_cap),
        .slow_stb_i(slow_stb),
        .slow_cap_i(slow_cap),
        .stamp_o   (stamp_o),
        .vld_o     (stamp_vld_o)
    );
endmodule

// File: tb/sim_dual_stamp_capture.sv
module sim_dual_stamp_capture;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0;
    logic [1:0]  lf = 2'd0;
    logic [1:0]  ls = 2'd0;
    logic [15:0] fast_cnt;
    logic [15:0] slow_cnt;
    logic [23:0] stamp;
    logic        vld;
    logic [23:0] ideal;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dual_stamp_capture u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .fast_lag_i (lf),
        .slow_lag_i (ls),
        .fast_cnt_o (fast_cnt),
        .slow_cnt_o (slow_cnt),
        .stamp_o    (stamp),
        .stamp_vld_o(vld)
    );

    // Ideal 24-bit clock count since reset
    always_ff @(posedge clk) begin
        if (!rst_n) ideal <= '0;
        else        ideal <= ideal + 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clamp_lag(input logic [1:0] l);
        return (l > 2'd2) ? 2 : int'(l);
    endfunction

    // Requirement tag for a pair, from the shared byte of each capture
    function automatic string pair_tag(input logic [23:0] ft, input logic [23:0] st);
        if (ft[15:8] == 8'hFF && st[15:8] == 8'h00) return "R5";
        if (ft[15:8] == 8'h00 && st[15:8] == 8'hFF) return "R6";
        return "R7";
    endfunction

    // R1: live counters against the ideal count
    task automatic check_counts();
        check("R1 align", {16'd0, slow_cnt[7:0], fast_cnt[15:8]}, {16'd0, fast_cnt[15:8], fast_cnt[15:8]});
        check("R1 ideal", {8'd0, slow_cnt, fast_cnt[7:0]}, {8'd0, ideal});
    endtask

    // Apply one event with the given lags and check the merged stamp
    task automatic fire(input logic [1:0] a, input logic [1:0] b, input int gap);
        logic [23:0] r0, exp_t, slow_t;
        int ea, eb, mx;
        @(negedge clk);
        lf = a;
        ls = b;
        @(negedge clk);
        r0 = ideal;
        evt = 1'b1;
        ea = clamp_lag(a);
        eb = clamp_lag(b);
        mx = (ea > eb) ? ea : eb;
        exp_t  = r0 + 24'(2 + ea);
        slow_t = r0 + 24'(2 + eb);
        repeat (3 + mx) @(posedge clk);
        #1;
        check("R9 cleared", {31'd0, vld}, 32'd0);
        @(posedge clk);
        #1;
        check("R4 valid", {31'd0, vld}, 32'd1);
        check({pair_tag(exp_t, slow_t), " R3 R10 stamp"}, {8'd0, stamp}, {8'd0, exp_t});
        check_counts();
        @(negedge clk);
        evt = 1'b0;
        repeat (8 + gap) @(posedge clk);
        #1;
        check("R8 hold", {7'd0, vld, stamp}, {7'd0, 1'b1, exp_t});
    endtask

    task automatic wait_ideal(input logic [23:0] t);
        do @(negedge clk); while (ideal != t);
    endtask

    initial begin
        int seed;
        logic [23:0] tgt;
        seed = $urandom(32'd2718);
        repeat (3) @(posedge clk);
        #1;
        // R2
        check("R2 fast", {16'd0, fast_cnt}, 32'd0);
        check("R2 slow", {16'd0, slow_cnt}, 32'd0);
        check("R2 stamp", {8'd0, stamp}, 32'd0);
        check("R2 vld", {31'd0, vld}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed skews, including a clamped lag (R10)
        fire(2'd0, 2'd0, 0);
        fire(2'd1, 2'd1, 3);
        fire(2'd2, 2'd0, 0);
        fire(2'd0, 2'd2, 5);
        fire(2'd3, 2'd1, 0);
        fire(2'd1, 2'd3, 2);

        // Random lags and spacing
        for (int i = 0; i < 150; i++) begin
            fire(2'($urandom % 4), 2'($urandom % 4), int'($urandom % 40));
        end

        // Events steered onto 256-clock boundaries (R7 with mismatched shared bytes)
        for (int i = 0; i < 60; i++) begin
            tgt = ((ideal + 24'd64) & 24'hFFFF00) + 24'h100 - 24'($urandom % 5);
            wait_ideal(tgt);
            fire(2'($urandom % 3), 2'($urandom % 3), 0);
        end

        // R5: fine capture just before the 65536 wrap, coarse capture just after
        wait_ideal(24'h00FFFB);
        fire(2'd0, 2'd2, 0);

        for (int i = 0; i < 40; i++) begin
            fire(2'($urandom % 4), 2'($urandom % 4), int'($urandom % 20));
        end

        // R6: fine capture just after the next wrap, coarse capture just before
        wait_ideal(24'h01FFFB);
        fire(2'd2, 2'd0, 0);

        // Zero skew straddling nothing, shortly after the wrap
        fire(2'd1, 2'd1, 0);
        check_counts();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule